// File: doc/BRIEF.md
# STN Grayscale Frame-Rate Modulation Engine

This block sits between a color lookup stage and a passive-matrix LCD panel driver. Every valid dot carries three 6-bit color components and a small screen position. The block turns each dot into one or three on/off drive bits for the current frame. Intermediate shades come from switching a dot on in a fixed share of successive frames. That share is set by a 5-bit level, which gives 32 shades per channel.

Two configuration inputs pick the behaviour. In monochrome operation, one intensity is formed, either from the green component alone or from a luma-style weighted sum, and it drives a single bit. In color operation, red, green and blue are modulated on their own, each with its own frame phase. A frame-start strobe moves a 5-bit frame counter forward. The two low bits of the dot's x and y position shift the phase, so that neighbouring dots at the same level do not switch in step.

Top module: `gs_frc_engine`

## Requirements
- R1: After a synchronous reset, out_valid and out_dots are 0 and the frame counter is 0. The first dot after reset is therefore modulated with frame count 0.
- R2: With cfg_color=0 and cfg_luma=0, the level is in_green>>1 and drives out_dots[0]. In monochrome operation out_dots[2:1] are always 0.
- R3: With cfg_color=0 and cfg_luma=1, the intensity is Y=(77*R+150*G+29*B)>>8, which is at most 63. The level is Y>>1 and drives out_dots[0].
- R4: With cfg_color=1, the red level (in_red>>1) drives out_dots[0], the green level drives out_dots[1] and the blue level drives out_dots[2]. The channel phase offsets are 0, 11 and 22 respectively. Monochrome uses offset 0.
- R5: The 5-bit frame counter increments on every cycle with frame_start=1 and wraps from 31 to 0. A dot presented in the same cycle as the strobe uses the value before the increment.
- R6: A channel is on exactly when bitrev5(P) < L. L is the level and P=(F+H+C) mod 32, where F is the frame count, H the position hash and C the channel offset. bitrev5 reverses the 5 bits. A fixed level L at a fixed position is therefore on in exactly L of any 32 consecutive frames.
- R7: Level 0 is never on. Level 31 is on in 31 of every 32 frames.
- R8: The position hash is the 4-bit value H={pos_x^pos_y, pos_x}, using 2-bit x and y.
- R9: Output is registered with one cycle of latency. out_valid equals in_valid of the previous cycle, and out_dots is 0 whenever out_valid is 0.
- R10: In color operation, cfg_luma has no effect on out_dots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_color | input | 1 | 1 = three-channel color operation, 0 = monochrome |
| cfg_luma | input | 1 | Monochrome intensity source: 1 = weighted luma, 0 = green only |
| frame_start | input | 1 | Advances the frame counter |
| in_valid | input | 1 | Dot data valid |
| in_red | input | 6 | Red component |
| in_green | input | 6 | Green component |
| in_blue | input | 6 | Blue component |
| pos_x | input | 2 | Low bits of dot column |
| pos_y | input | 2 | Low bits of dot row |
| out_valid | output | 1 | Drive bits valid |
| out_dots | output | 3 | Drive bits; bit 0 alone in monochrome |

## Verification
The bench holds a dot at fixed levels for 32 consecutive frames and counts the on frames. A wrong comparison, for example `<=` instead of `<`, would light level 0 or reach 32 of 32 at level 31, and an off-by-one shows up as an L±1 count. A long run of frame strobes crosses the 31-to-0 wrap, where a counter that saturates or wraps early would drift from the model. Randomized positions and modes catch a wrong hash or channel offset, or bits sent to the wrong lane. Extreme luma inputs catch a truncated weight sum. Bubbles in in_valid catch stale drive bits leaking through while the output is not valid.

// File: rtl/gs_pkg.sv
package gs_pkg;

    localparam int COMP_W  = 6;
    localparam int LVL_W   = 5;
    localparam int POS_W   = 2;
    localparam int NUM_CH  = 3;
    localparam int W_SHIFT = 8;
    localparam int SUM_W   = COMP_W + W_SHIFT;
    localparam int HASH_W  = 2 * POS_W;

    localparam logic [SUM_W-1:0] W_RED   = SUM_W'(77);
    localparam logic [SUM_W-1:0] W_GREEN = SUM_W'(150);
    localparam logic [SUM_W-1:0] W_BLUE  = SUM_W'(29);

    typedef logic [COMP_W-1:0] comp_t;
    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef struct packed {
        comp_t red;
        comp_t green;
        comp_t blue;
    } rgb_t;

    typedef enum logic [1:0] {
        MODE_MONO_GREEN = 2'd0,
        MODE_MONO_LUMA  = 2'd1,
        MODE_COLOR      = 2'd2
    } gs_mode_e;

    typedef level_t [NUM_CH-1:0] lvl_vec_t;

    function automatic level_t chan_offset(input int ch);
        case (ch)
            0:       return level_t'(0);
            1:       return level_t'(11);
            default: return level_t'(22);
        endcase
    endfunction

    function automatic comp_t luma6(input rgb_t px);
        logic [SUM_W-1:0] acc;
        acc = W_RED   * SUM_W'(px.red)
            + W_GREEN * SUM_W'(px.green)
            + W_BLUE  * SUM_W'(px.blue);
        return acc[SUM_W-1:W_SHIFT];
    endfunction

    function automatic level_t to_level(input comp_t c);
        return c[COMP_W-1:COMP_W-LVL_W];
    endfunction

    function automatic level_t bit_reverse(input level_t v);
        level_t r;
        for (int i = 0; i < LVL_W; i++) begin
            r[i] = v[LVL_W-1-i];
        end
        return r;
    endfunction

    function automatic level_t pos_hash(input pos_t x, input pos_t y);
        return level_t'({x ^ y, x});
    endfunction

    function automatic gs_mode_e decode_mode(input logic color, input logic luma);
        if (color)     return MODE_COLOR;
        else if (luma) return MODE_MONO_LUMA;
        else           return MODE_MONO_GREEN;
    endfunction

endpackage

// File: rtl/gs_frame_counter.sv
module gs_frame_counter
    import gs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    output level_t count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (advance) begin
            count <= count + level_t'(1);
        end
    end

    p_frame_step_r5: assert property (@(posedge clk) disable iff (rst)
        advance |=> (count == level_t'($past(count) + level_t'(1))));

    p_frame_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(count));

endmodule

// File: rtl/gs_intensity.sv
module gs_intensity
    import gs_pkg::*;
(
    input  gs_mode_e mode,
    input  rgb_t     pixel,
    output lvl_vec_t levels
);

    comp_t mono_src;

    always_comb begin
        mono_src = (mode == MODE_MONO_LUMA) ? luma6(pixel) : pixel.green;
        levels   = '0;
        if (mode == MODE_COLOR) begin
            levels[0] = to_level(pixel.red);
            levels[1] = to_level(pixel.green);
            levels[2] = to_level(pixel.blue);
        end else begin
            levels[0] = to_level(mono_src);
        end
    end

endmodule

// File: rtl/gs_frc_cell.sv
module gs_frc_cell
    import gs_pkg::*;
#(
    parameter level_t PHASE_OFF = '0
) (
    input  level_t level,
    input  level_t base_phase,
    output logic   dot_on
);

    level_t phase;
    level_t rank;

    always_comb begin
        phase  = base_phase + PHASE_OFF;
        rank   = bit_reverse(phase);
        dot_on = (rank < level);
    end

endmodule

// File: rtl/gs_frc_engine.sv
module gs_frc_engine
    import gs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_color,
    input  logic       cfg_luma,
    input  logic       frame_start,
    input  logic       in_valid,
    input  logic [5:0] in_red,
    input  logic [5:0] in_green,
    input  logic [5:0] in_blue,
    input  logic [1:0] pos_x,
    input  logic [1:0] pos_y,
    output logic       out_valid,
    output logic [2:0] out_dots
);

    gs_mode_e            mode;
    rgb_t                pixel;
    lvl_vec_t            levels;
    level_t              frame_cnt;
    level_t              base_phase;
    logic [NUM_CH-1:0]   dots_next;

    assign mode       = decode_mode(cfg_color, cfg_luma);
    assign pixel      = '{red: in_red, green: in_green, blue: in_blue};
    assign base_phase = frame_cnt + pos_hash(pos_x, pos_y);

    gs_frame_counter u_frame (
        .clk     (clk),
        .rst     (rst),
        .advance (frame_start),
        .count   (frame_cnt)
    );

    gs_intensity u_int (
        .mode   (mode),
        .pixel  (pixel),
        .levels (levels)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        gs_frc_cell #(
            .PHASE_OFF (chan_offset(ch))
        ) u_cell (
            .level      (levels[ch]),
            .base_phase (base_phase),
            .dot_on     (dots_next[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_dots  <= '0;
        end else begin
            out_valid <= in_valid;
            out_dots  <= in_valid ? dots_next : '0;
        end
    end

    p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && out_dots == '0));

    p_mono_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg_color) |=> (out_dots[2:1] == 2'b00));

    p_level0_dark_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && levels[0] == '0) |=> !out_dots[0]);

    p_out_bounded_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_dots == '0));

endmodule

// File: tb/sim_gs_frc_engine.sv
module sim_gs_frc_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_color = 1'b0;
    logic       cfg_luma = 1'b0;
    logic       frame_start = 1'b0;
    logic       in_valid = 1'b0;
    logic [5:0] in_red = '0;
    logic [5:0] in_green = '0;
    logic [5:0] in_blue = '0;
    logic [1:0] pos_x = '0;
    logic [1:0] pos_y = '0;
    logic       out_valid;
    logic [2:0] out_dots;

    always #10 clk = ~clk;

    gs_frc_engine u0 (
        .clk(clk), .rst(rst), .cfg_color(cfg_color), .cfg_luma(cfg_luma),
        .frame_start(frame_start), .in_valid(in_valid),
        .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
        .pos_x(pos_x), .pos_y(pos_y),
        .out_valid(out_valid), .out_dots(out_dots)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    fc       = 0;
    int    exp_v    = 0;
    int    exp_d    = 0;
    int    acc[3];
    string tag      = "R1";
    bit    done     = 0;

    function automatic int brev(int v);
        int r = 0;
        for (int i = 0; i < 5; i++) if ((v >> i) & 1) r |= 1 << (4 - i);
        return r;
    endfunction

    function automatic int dot_model(int lvl, int frame, int x, int y, int off);
        int h = (((x ^ y) & 3) << 2) | (x & 3);
        int p = (frame + h + off) % 32;
        return (brev(p) < lvl) ? 1 : 0;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic step(bit cc, bit cl, bit v, bit fs, int r, int g, int b, int x, int y);
        int d = 0;
        @(negedge clk);
        check(out_valid == exp_v[0] && int'(out_dots) == exp_d, tag,
              "out_valid*8+out_dots", int'(out_valid) * 8 + int'(out_dots), exp_v * 8 + exp_d);
        if (out_valid) for (int i = 0; i < 3; i++) acc[i] += int'(out_dots[i]);
        cfg_color = cc; cfg_luma = cl; in_valid = v; frame_start = fs;
        in_red = 6'(r); in_green = 6'(g); in_blue = 6'(b);
        pos_x = 2'(x); pos_y = 2'(y);
        if (v) begin
            if (cc) begin
                d |= dot_model(r >> 1, fc, x, y, 0);
                d |= dot_model(g >> 1, fc, x, y, 11) << 1;
                d |= dot_model(b >> 1, fc, x, y, 22) << 2;
            end else if (cl) begin
                d = dot_model(((77 * r + 150 * g + 29 * b) / 256) >> 1, fc, x, y, 0);
            end else begin
                d = dot_model(g >> 1, fc, x, y, 0);
            end
        end
        exp_v = v ? 1 : 0;
        exp_d = d;
        if (fs) fc = (fc + 1) % 32;
    endtask

    task automatic clear_acc();
        for (int i = 0; i < 3; i++) acc[i] = 0;
    endtask

    task automatic count_run(bit cc, int r, int g, int b, int x, int y);
        clear_acc();
        for (int f = 0; f < 32; f++) step(cc, 0, 1, 1, r, g, b, x, y);
        step(cc, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run incomplete actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_dots == 3'b000, "R1", "out_dots after reset", int'(out_dots), 0);
        // R1: first dot uses frame count 0 (covered by model with fc=0)
        tag = "R1";
        step(0, 0, 1, 0, 0, 40, 0, 0, 0);

        tag = "R2";
        for (int i = 0; i < 96; i++)
            step(0, 0, 1, (i % 7) == 0, $urandom % 64, $urandom % 64, $urandom % 64, $urandom % 4, $urandom % 4);

        tag = "R3";
        step(0, 1, 1, 0, 63, 63, 63, 1, 2);
        step(0, 1, 1, 0, 63, 0, 0, 2, 1);
        step(0, 1, 1, 0, 0, 0, 63, 3, 3);
        for (int i = 0; i < 96; i++)
            step(0, 1, 1, (i % 5) == 0, $urandom % 64, $urandom % 64, $urandom % 64, $urandom % 4, $urandom % 4);

        tag = "R4";
        for (int i = 0; i < 96; i++)
            step(1, $urandom % 2, 1, (i % 3) == 0, $urandom % 64, $urandom % 64, $urandom % 64, $urandom % 4, $urandom % 4);

        tag = "R10";
        for (int i = 0; i < 32; i++)
            step(1, i % 2, 1, (i % 4) == 0, 37, 21, 50, i % 4, (i / 4) % 4);

        tag = "R5";
        for (int i = 0; i < 80; i++)
            step(i % 2, 0, 1, 1, 44, 27, 9, i % 4, (i / 3) % 4);

        tag = "R8";
        for (int x = 0; x < 4; x++)
            for (int y = 0; y < 4; y++)
                step(1, 0, 1, 0, 30, 30, 30, x, y);

        tag = "R6";
        count_run(0, 0, 34, 0, 1, 2);
        check(acc[0] == 17, "R6", "on frames for level 17", acc[0], 17);
        count_run(1, 10, 0, 10, 3, 0);
        check(acc[0] == 5 && acc[2] == 5, "R6", "color on frames red+blue level 5", acc[0] + acc[2], 10);

        tag = "R7";
        count_run(0, 63, 0, 63, 2, 3);
        check(acc[0] == 0, "R7", "on frames for level 0", acc[0], 0);
        count_run(0, 0, 63, 0, 0, 1);
        check(acc[0] == 31, "R7", "on frames for level 31", acc[0], 31);
        count_run(1, 0, 62, 0, 1, 1);
        check(acc[1] == 31 && acc[0] == 0 && acc[2] == 0, "R7",
              "color green 31 / red,blue 0", acc[1] * 100 + acc[0] + acc[2], 3100);

        tag = "R9";
        for (int i = 0; i < 64; i++)
            step(i % 3 == 0, 0, (i % 2) == 0, (i % 5) == 0, 63, 63, 63, i % 4, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule